// File: doc/BRIEF.md
# Flash Page-Buffer Commit Sequencer

This block drives a serial flash device over SPI mode 0. It issues the one command that writes the contents of one of the device's two SRAM page buffers into a page of the main array. The user side gives a single-cycle `start` pulse together with a buffer choice, an erase choice and a 24-bit address. The block then takes these steps:

- It picks the opcode from the buffer and erase choices.
- It shifts out a 32-bit frame: the opcode, then the address with its byte-in-page bits forced to zero.
- It raises chip select on an SCK falling edge, which commits the command in the device.
- It stays busy for a parameterised count of system clocks, so the device's self-timed erase/program interval has passed before `done` is signalled.

If the block is built for a device with only one buffer, any request for the second buffer is refused. No frame is sent and an error pulse is given instead.

Top module: `flash_commit_seq`

## Requirements
- R1: The opcode is chosen as follows. `buf_sel`=0 selects buffer 1 and `buf_sel`=1 selects buffer 2; `erase_en`=1 selects built-in erase. Buffer 1 with erase sends 0x83, buffer 2 with erase sends 0x86, buffer 1 without erase sends 0x88, and buffer 2 without erase sends 0x89.
- R2: Each frame is 32 bits, sent most significant bit first: the opcode byte, then address bits 23:16, 15:8 and 7:0.
- R3: The low `OFFSET_BITS` bits of the address (the byte-in-page field) are sent as zero. All higher bits are sent as given.
- R4: `cs_n` stays low without a break for the whole frame, and exactly 32 SCK rising edges occur while it is low. SCK is high only while `cs_n` is low.
- R5: SPI mode 0 is used. MOSI changes only while SCK is low, so it is stable whenever SCK is high.
- R6: `cs_n` rises in the same system-clock cycle as the SCK falling edge that ends the 32nd bit.
- R7: After `cs_n` rises, `busy` stays high for exactly `WAIT_CYCLES` system clocks. Then `done` is high for one cycle, during which `busy` is low.
- R8: A `start` that arrives while `busy` is high is ignored and produces no frame. The inputs are captured when `start` is accepted, so changing them later does not alter the frame.
- R9: With `SINGLE_BUF`=1, a `start` with `buf_sel`=1 sends no frame and leaves `busy` low. Instead, `err` is high for one cycle, in the cycle after `start`.
- R10: In reset and when idle, `cs_n` is high, SCK is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to commit a buffer |
| buf_sel | input | 1 | 0 selects buffer 1, 1 selects buffer 2 |
| erase_en | input | 1 | 1 erases the page before programming it |
| page_addr | input | 24 | Target address; the byte-in-page bits are ignored |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle pulse when the program interval has elapsed |
| err | output | 1 | One-cycle pulse when a buffer-2 request is refused |

## Verification
The hardest case to reach from the ports is a second request that lands while a command is already in flight. That covers both the shifting phase and the silent wait after chip select has risen, and the second request must leave the device untouched. The bench fires extra start pulses with different buffer, erase and address values at points inside both phases. The scoreboard then shows that only the queued frames appear, in order. It also changes the address inputs on the cycle after each accepted start, so any late sampling of the inputs shows up as a corrupted frame.

// File: rtl/flash_commit_seq.sv
module flash_commit_seq #(
  parameter int CLK_DIV     = 2,
  parameter int WAIT_CYCLES = 2000000,
  parameter int OFFSET_BITS = 9,
  parameter bit SINGLE_BUF  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        buf_sel,
  input  logic        erase_en,
  input  logic [23:0] page_addr,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [23:0] ADDR_MASK = ~((24'd1 << OFFSET_BITS) - 24'd1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_WAIT} state_t;

  state_t            state;
  logic [31:0]       sr;
  logic [4:0]        bit_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic [7:0]        opcode;

  always_comb begin
    case ({buf_sel, erase_en})
      2'b01:   opcode = 8'h83;
      2'b11:   opcode = 8'h86;
      2'b00:   opcode = 8'h88;
      default: opcode = 8'h89;
    endcase
  end

  wire idle   = (state == S_IDLE);
  wire refuse = start && idle && SINGLE_BUF && buf_sel;
  wire accept = start && idle && !(SINGLE_BUF && buf_sel);
  wire tick   = (div_cnt == DIV_W'(CLK_DIV - 1));

  assign busy = !idle;
  assign mosi = !cs_n && sr[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sr       <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      wait_cnt <= '0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= refuse;
      case (state)
        S_IDLE: if (accept) begin
          sr      <= {opcode, page_addr & ADDR_MASK};
          cs_n    <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
          state   <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          div_cnt <= '0;
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            if (bit_cnt == 5'd31) begin
              cs_n     <= 1'b1;
              wait_cnt <= '0;
              state    <= S_WAIT;
            end else begin
              sr      <= {sr[30:0], 1'b0};
              bit_cnt <= bit_cnt + 5'd1;
            end
          end
        end else div_cnt <= div_cnt + DIV_W'(1);
        S_WAIT: if (wait_cnt == WAIT_W'(WAIT_CYCLES - 1)) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end else wait_cnt <= wait_cnt + WAIT_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_commit_seq_chk.sv
module flash_commit_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err
);
  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));
  p_sck_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_cs_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $fell(sck));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
  p_refuse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy));
endmodule

bind flash_commit_seq flash_commit_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .busy(busy), .done(done), .err(err)
);

// File: tb/flash_commit_seq_test.sv
module flash_commit_seq_test;
  localparam int DIV  = 3;
  localparam int WAIT = 40;
  localparam int OFS  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 0, buf_sel = 0, erase_en = 0;
  logic [23:0] page_addr = '0;
  logic        sck, cs_n, mosi, busy, done, err;

  logic        s_start = 0, s_buf = 0;
  logic        s_sck, s_cs_n, s_mosi, s_busy, s_done, s_err;

  flash_commit_seq #(.CLK_DIV(DIV), .WAIT_CYCLES(WAIT), .OFFSET_BITS(OFS), .SINGLE_BUF(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_sel(buf_sel), .erase_en(erase_en),
    .page_addr(page_addr), .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy),
    .done(done), .err(err));

  flash_commit_seq #(.CLK_DIV(DIV), .WAIT_CYCLES(WAIT), .OFFSET_BITS(OFS), .SINGLE_BUF(1'b1)) uut_one (
    .clk(clk), .rst_n(rst_n), .start(s_start), .buf_sel(s_buf), .erase_en(1'b1),
    .page_addr(24'h00AA00), .sck(s_sck), .cs_n(s_cs_n), .mosi(s_mosi), .busy(s_busy),
    .done(s_done), .err(s_err));

  int checks = 0, errors = 0, frames = 0, pushes = 0;
  bit finished = 0;
  logic [31:0] expq[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] want_op(input logic b, input logic e);
    if (!b && e) return 8'h83;
    if (b && e)  return 8'h86;
    if (!b)      return 8'h88;
    return 8'h89;
  endfunction

  // Monitor for the dual-buffer instance
  logic        p_sck = 0, p_cs = 1, p_mosi = 0, mosi_bad = 0, waiting = 0;
  logic [31:0] cap = '0;
  int          nbits = 0, wcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin nbits = 0; cap = '0; mosi_bad = 0; end
      if (!cs_n && sck && p_sck && mosi != p_mosi) mosi_bad = 1;
      if (!cs_n && sck && !p_sck) begin cap = {cap[30:0], mosi}; nbits++; end
      if (waiting) begin
        wcnt++;
        if (done) begin
          check(wcnt == WAIT && !busy, "R7 wait length", wcnt, WAIT);
          check(cs_n && !sck, "R10 idle lines after done", {cs_n, sck}, 2'b10);
          waiting = 0;
        end
      end
      if (!p_cs && cs_n) begin
        frames++;
        check(p_sck && !sck, "R6 cs rise on sck fall", {p_sck, sck}, 2'b10);
        check(nbits == 32, "R4 bit count", nbits, 32);
        check(!mosi_bad, "R5 mosi stable while sck high", mosi_bad, 0);
        if (expq.size() == 0) check(0, "R8 unexpected frame", cap, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check(cap == e, "R1 R2 R3 frame content", cap, e);
        end
        waiting = 1; wcnt = 0;
      end
      p_sck = sck; p_cs = cs_n; p_mosi = mosi;
    end
  end

  task automatic commit(input logic b, input logic e, input logic [23:0] a, input int interfere);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; buf_sel = b; erase_en = e; page_addr = a;
    expq.push_back({want_op(b, e), a & ~24'h0001FF});
    pushes++;
    @(negedge clk);
    start = 0; buf_sel = ~b; erase_en = ~e; page_addr = ~a;
    check(busy && !cs_n, "R8 start accepted", {busy, cs_n}, 2'b10);
    if (interfere != 0) begin
      repeat (interfere) @(negedge clk);
      start = 1; buf_sel = ~b; erase_en = ~e; page_addr = a ^ 24'h5A5A5A;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !busy && !done, "R10 reset state", {cs_n, sck, busy, done}, 4'b1000);
    check(s_cs_n && !s_sck && !s_busy && !s_err, "R10 reset state single", {s_cs_n, s_sck, s_busy, s_err}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    commit(1'b0, 1'b1, 24'hA5C3E7, 0);  // R1 0x83
    commit(1'b1, 1'b1, 24'hFFFFFF, 0);  // R1 0x86, R3 offset zeroed
    commit(1'b0, 1'b0, 24'h000000, 0);  // R1 0x88
    commit(1'b1, 1'b0, 24'h123456, 0);  // R1 0x89
    commit(1'b0, 1'b1, 24'h8001FF, 30); // R8 ignored during shifting
    commit(1'b1, 1'b0, 24'h7FFE00, 200);// R8 ignored during wait
    commit(1'b1, 1'b1, 24'h3C3C3C, 3);

    repeat (5) @(negedge clk);
    check(expq.size() == 0 && frames == pushes, "R8 frame count", frames, pushes);

    // R9 single-buffer refusal
    s_start = 1; s_buf = 1;
    @(negedge clk);
    s_start = 0;
    check(s_err && !s_busy && s_cs_n, "R9 refused request", {s_err, s_busy, s_cs_n}, 3'b101);
    begin
      int lows = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!s_cs_n || s_busy || s_err) lows++;
      end
      check(lows == 0, "R9 no frame and single err pulse", lows, 0);
    end
    s_start = 1; s_buf = 0;
    @(negedge clk);
    s_start = 0;
    check(s_busy && !s_err && !s_cs_n, "R9 buffer 1 still accepted", {s_busy, s_err, s_cs_n}, 3'b100);
    while (!s_done) @(negedge clk);
    @(negedge clk);
    check(s_cs_n && !s_busy, "R10 single idle after done", {s_cs_n, s_busy}, 2'b10);

    wrap_up();
  end
endmodule